// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. A host places a byte on the data input and pulses a write strobe for one system-clock cycle. The byte waits in a one-entry holding register. When the line is idle, the byte moves into a shift register and is sent out. The bit rate comes from an external transmit clock. That clock is brought into the system clock domain, and its rising edges are divided by 1, 16 or 64.

A 3-bit format code selects the frame layout. There are eight layouts, built from 7 or 8 data bits, even, odd or no parity, and one or two stop bits. The format is captured when a byte enters the shift register. A 2-bit divisor code selects the bit-clock ratio, and its fourth value holds the transmitter in reset. An empty flag tells the host when the holding register can take another byte. A second byte can therefore be queued while the first one is still on the line.

Top module: `sertx_top`

## Requirements
- R1: Every frame starts with one low start bit. The data bits follow, least significant bit first, then the parity bit if the format has one, then the high stop bits.
- R2: Format codes 000 to 011 send 7 data bits (bits 6..0 of the byte) plus a parity bit. Codes 000 and 001 use two stop bits, and codes 010 and 011 use one. Code bit 0 picks the parity: 0 makes the count of ones across data and parity even, 1 makes it odd.
- R3: Format code 100 sends 8 data bits with no parity and two stop bits. Code 101 sends 8 data bits with no parity and one stop bit.
- R4: Format codes 110 and 111 send 8 data bits, a parity bit and one stop bit. Code 110 uses even parity and code 111 uses odd parity.
- R5: Every bit, the start bit included, lasts a fixed number of rising edges of the transmit clock. Divisor code 00 gives 1 edge, 01 gives 16 and 10 gives 64. The line changes only on the bit boundaries that these edges mark.
- R6: While the divisor code is 11, the line is high and the empty flag is 1. A write strobe during this time is ignored, so no frame is sent after the code is changed back.
- R7: A write strobe that is not in reset clears the empty flag from the next cycle on.
- R8: The empty flag returns to 1 on the same clock edge at which the queued byte enters the shift register and the start bit begins. A byte written during a frame is sent after that frame.
- R9: The synchronous active-high reset, applied even in the middle of a frame, leaves the line high and the empty flag at 1.
- R10: With nothing queued, the line stays high after the last stop bit.
- R11: A second write while a byte is still queued replaces the queued byte. Only the newer byte is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe that queues wr_data |
| wr_data | input | 8 | Byte to send |
| fmt_code | input | 3 | Frame layout selector |
| div_code | input | 2 | Bit-clock divisor selector; 11 holds the block in reset |
| tx_clk | input | 1 | External transmit bit clock, asynchronous |
| tx_line | output | 1 | Serial data output, idles high |
| buf_empty | output | 1 | High when a new byte can be written |

## Verification
The bench uses the default parameters: divisors of 16 and 64 and a two-stage synchronizer. The transmit clock has a period of four system cycles, so one bit lasts 4, 64 or 256 cycles. These values let the bench measure the exact start-bit length for every divisor code. They also let it sample every bit of all eight layouts at its centre, and send long frames at the ×64 ratio within the cycle budget. They are slow enough that a byte can be queued, or overwritten, during a frame, and that a soft or hard reset can be applied in the middle of a frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 12;
  localparam int LEN_W   = 4;

  typedef struct packed {
    logic eight;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_fmt_t;

  function automatic frame_fmt_t decode_fmt(input logic [2:0] code);
    frame_fmt_t f;
    f.eight    = code[2];
    f.par_en   = !code[2] || code[1];
    f.par_odd  = code[0];
    f.two_stop = code[2] ? (code[1:0] == 2'b00) : !code[1];
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input frame_fmt_t f);
    logic [LEN_W-1:0] n;
    n = LEN_W'(1) + (f.eight ? LEN_W'(8) : LEN_W'(7));
    n = n + LEN_W'(f.par_en) + (f.two_stop ? LEN_W'(2) : LEN_W'(1));
    return n;
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [BYTE_W-1:0] d,
                                                     input frame_fmt_t f);
    logic [FRAME_W-1:0] v;
    logic [BYTE_W-1:0]  used;
    logic               par;
    v    = '1;
    v[0] = 1'b0;
    used = f.eight ? d : {1'b0, d[BYTE_W-2:0]};
    for (int i = 0; i < BYTE_W; i++) begin
      if (i < BYTE_W - 1 || f.eight) v[1+i] = d[i];
    end
    par = (^used) ^ f.par_odd;
    if (f.par_en) begin
      if (f.eight) v[BYTE_W+1] = par;
      else         v[BYTE_W]   = par;
    end
    return v;
  endfunction

endpackage

// File: rtl/sertx_tick_gen.sv
module sertx_tick_gen #(
  parameter int DIV_MID     = 16,
  parameter int DIV_HI      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       srst,
  input  logic       tx_clk,
  input  logic [1:0] div_code,
  output logic       tick
);
  localparam int CNT_W = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;

  logic [SYNC_STAGES:0] sync_q;
  logic                 clk_rise;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     limit;
  logic                 tick_q;

  always_ff @(posedge clk) begin
    if (srst) sync_q <= '0;
    else      sync_q <= {sync_q[SYNC_STAGES-1:0], tx_clk};
  end

  assign clk_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_comb begin
    case (div_code)
      2'b00:   limit = '0;
      2'b01:   limit = CNT_W'(DIV_MID - 1);
      default: limit = CNT_W'(DIV_HI - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (clk_rise) begin
      if (cnt_q >= limit) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              srst,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              take,
  output logic [BYTE_W-1:0] hold_data,
  output logic              full,
  output logic              empty
);
  logic [BYTE_W-1:0] data_q;
  logic              full_q;
  logic              empty_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (wr_stb) begin
      data_q  <= wr_data;
      full_q  <= 1'b1;
      empty_q <= 1'b0;
    end else if (take) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end
  end

  assign hold_data = data_q;
  assign full      = full_q;
  assign empty     = empty_q;
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              srst,
  input  logic              tick,
  input  logic              full,
  input  logic [BYTE_W-1:0] hold_data,
  input  logic [2:0]        fmt_code,
  output logic              take,
  output logic              line
);
  logic [FRAME_W-1:0] sreg_q;
  logic [LEN_W-1:0]   left_q;
  logic               busy;
  frame_fmt_t         fmt;

  assign fmt  = decode_fmt(fmt_code);
  assign busy = (left_q != '0);
  assign take = tick && !busy && full;

  always_ff @(posedge clk) begin
    if (srst) begin
      sreg_q <= '1;
      left_q <= '0;
    end else if (tick) begin
      if (busy) begin
        sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
      end else if (full) begin
        sreg_q <= build_frame(hold_data, fmt);
        left_q <= frame_len(fmt);
      end
    end
  end

  assign line = sreg_q[0];
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_MID     = 16,
  parameter int DIV_HI      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic [2:0] fmt_code,
  input  logic [1:0] div_code,
  input  logic       tx_clk,
  output logic       tx_line,
  output logic       buf_empty
);
  logic              srst;
  logic              tick;
  logic              take;
  logic              full;
  logic [BYTE_W-1:0] hold_data;

  assign srst = rst || (div_code == 2'b11);

  sertx_tick_gen #(
    .DIV_MID(DIV_MID), .DIV_HI(DIV_HI), .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk(clk), .srst(srst), .tx_clk(tx_clk), .div_code(div_code), .tick(tick)
  );

  sertx_hold u_hold (
    .clk(clk), .srst(srst), .wr_stb(wr_stb), .wr_data(wr_data), .take(take),
    .hold_data(hold_data), .full(full), .empty(buf_empty)
  );

  sertx_shifter u_shift (
    .clk(clk), .srst(srst), .tick(tick), .full(full), .hold_data(hold_data),
    .fmt_code(fmt_code), .take(take), .line(tx_line)
  );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_stb,
  input logic [1:0] div_code,
  input logic       tick,
  input logic       tx_line,
  input logic       buf_empty
);
  p_hw_reset_idle_r9: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (tx_line && buf_empty));

  p_soft_reset_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(div_code == 2'b11)) |-> (tx_line && buf_empty));

  p_write_fills_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && div_code != 2'b11) |=> !buf_empty);

  p_transfer_starts_frame_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(buf_empty) && !$past(rst) && !$past(div_code == 2'b11)) |-> $fell(tx_line));

  p_bit_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick) && !$past(div_code == 2'b11)) |-> $stable(tx_line));
endmodule

bind sertx_top sertx_chk u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .div_code(div_code),
  .tick(tick), .tx_line(tx_line), .buf_empty(buf_empty)
);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] fmt_code = 3'b101;
  logic [1:0] div_code = 2'b00;
  logic       tx_clk = 1'b0;
  logic       tx_line;
  logic       buf_empty;

  int total = 0;
  int bad = 0;
  localparam int CLK_RATIO = 4;

  sertx_top u_dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .fmt_code(fmt_code), .div_code(div_code), .tx_clk(tx_clk),
    .tx_line(tx_line), .buf_empty(buf_empty)
  );

  always #2 clk = ~clk;

  initial begin
    forever begin
      repeat (CLK_RATIO / 2) @(negedge clk);
      tx_clk = ~tx_clk;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bit_cycles(input logic [1:0] dv);
    case (dv)
      2'b00:   return CLK_RATIO;
      2'b01:   return 16 * CLK_RATIO;
      default: return 64 * CLK_RATIO;
    endcase
  endfunction

  function automatic int exp_len(input logic [2:0] f);
    case (f)
      3'd0, 3'd1: return 11;
      3'd2, 3'd3: return 10;
      3'd4:       return 11;
      3'd5:       return 10;
      default:    return 11;
    endcase
  endfunction

  function automatic logic [11:0] exp_bits(input logic [7:0] d, input logic [2:0] f);
    logic [11:0] b;
    int nd;
    logic p;
    b = '1;
    b[0] = 1'b0;
    nd = (f < 3'd4) ? 7 : 8;
    p = 1'b0;
    for (int i = 0; i < nd; i++) begin
      b[1+i] = d[i];
      p = p ^ d[i];
    end
    if (f < 3'd4 || f > 3'd5) b[1+nd] = p ^ f[0];
    return b;
  endfunction

  function automatic string fmt_tag(input logic [2:0] f);
    if (f < 3'd4) return "R2";
    if (f < 3'd6) return "R3";
    return "R4";
  endfunction

  task automatic write_byte(input logic [7:0] d);
    wr_data = d;
    wr_stb = 1'b1;
    step(1);
    wr_stb = 1'b0;
    chk("R7 empty cleared after write", buf_empty, 0);
  endtask

  task automatic wait_start(output bit ok);
    int n;
    n = 0;
    while (tx_line !== 1'b0 && n < 20000) begin
      step(1);
      n++;
    end
    ok = (tx_line === 1'b0);
  endtask

  task automatic sample_frame(input logic [7:0] d, input logic [2:0] f,
                              input logic [1:0] dv, input int elapsed, input string tag);
    int np, len, at;
    logic [11:0] b;
    np = bit_cycles(dv);
    len = exp_len(f);
    b = exp_bits(d, f);
    at = elapsed;
    for (int k = 0; k < len; k++) begin
      step(np / 2 + k * np - at);
      at = np / 2 + k * np;
      chk($sformatf("R1 %s byte %0h fmt %0d bit %0d", tag, d, f, k), tx_line, b[k]);
    end
  endtask

  task automatic count_lows(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      step(1);
      if (tx_line == 1'b0) lows++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok;
    int lows;
    int unsigned seed;
    logic [7:0] d;
    logic [2:0] f;
    logic [1:0] dv;

    seed = $urandom(32'd4242);
    step(5);
    chk("R9 line high in reset", tx_line, 1);
    chk("R9 empty in reset", buf_empty, 1);
    rst = 1'b0;
    step(4);
    chk("R10 idle line high", tx_line, 1);

    // R5: start bit length for each divisor code (byte 0x01, bit 0 is high)
    for (int dc = 0; dc < 3; dc++) begin
      div_code = 2'(dc);
      fmt_code = 3'b101;
      step(2);
      write_byte(8'h01);
      wait_start(ok);
      chk("R5 frame started", ok, 1);
      lows = 0;
      while (tx_line == 1'b0 && lows < 1000) begin
        step(1);
        lows++;
      end
      chk($sformatf("R5 start bit cycles div %0d", dc), lows, bit_cycles(2'(dc)));
      step(11 * bit_cycles(2'(dc)));
    end

    // R2 R3 R4: every format code
    div_code = 2'b00;
    for (int fc = 0; fc < 8; fc++) begin
      fmt_code = 3'(fc);
      d = (fc % 2 == 0) ? 8'hA5 : 8'h3C;
      step(2);
      write_byte(d);
      wait_start(ok);
      chk("R1 frame started", ok, 1);
      sample_frame(d, 3'(fc), 2'b00, 0, fmt_tag(3'(fc)));
      step(3 * CLK_RATIO);
      chk("R10 idle after frame", tx_line, 1);
      chk("R10 empty after frame", buf_empty, 1);
    end

    // R8: queue a second byte during a frame
    div_code = 2'b01;
    fmt_code = 3'b110;
    step(2);
    write_byte(8'h5A);
    wait_start(ok);
    chk("R8 empty at frame start", buf_empty, 1);
    write_byte(8'hC3);
    sample_frame(8'h5A, 3'b110, 2'b01, 1, "R8 first");
    wait_start(ok);
    chk("R8 queued frame started", ok, 1);
    sample_frame(8'hC3, 3'b110, 2'b01, 0, "R8 second");

    // R11: overwrite a queued byte
    div_code = 2'b00;
    fmt_code = 3'b011;
    step(2 * CLK_RATIO);
    write_byte(8'h11);
    wait_start(ok);
    write_byte(8'h22);
    write_byte(8'h33);
    sample_frame(8'h11, 3'b011, 2'b00, 2, "R11 first");
    wait_start(ok);
    sample_frame(8'h33, 3'b011, 2'b00, 0, "R11 replaced");
    count_lows(30 * CLK_RATIO, lows);
    chk("R11 stale byte not sent", lows, 0);

    // R6: divisor code 11 holds the block in reset
    div_code = 2'b01;
    step(2);
    write_byte(8'hF0);
    wait_start(ok);
    step(20);
    div_code = 2'b11;
    step(1);
    chk("R6 line high in soft reset", tx_line, 1);
    chk("R6 empty in soft reset", buf_empty, 1);
    wr_data = 8'h00;
    wr_stb = 1'b1;
    step(1);
    wr_stb = 1'b0;
    chk("R6 write ignored, empty kept", buf_empty, 1);
    step(3);
    div_code = 2'b00;
    count_lows(40 * CLK_RATIO, lows);
    chk("R6 no frame after soft reset", lows, 0);
    chk("R6 empty after soft reset", buf_empty, 1);

    // R9: hard reset in the middle of a frame
    fmt_code = 3'b100;
    div_code = 2'b01;
    step(2);
    write_byte(8'h00);
    write_byte(8'h0F);
    wait_start(ok);
    step(30);
    rst = 1'b1;
    step(1);
    chk("R9 line high after mid-frame reset", tx_line, 1);
    chk("R9 empty after mid-frame reset", buf_empty, 1);
    rst = 1'b0;
    count_lows(40 * CLK_RATIO, lows);
    chk("R9 nothing sent after reset", lows, 0);

    // random frames
    for (int it = 0; it < 24; it++) begin
      d = 8'($urandom);
      f = 3'($urandom % 8);
      dv = ($urandom % 6 == 0) ? 2'b10 : 2'($urandom % 2);
      fmt_code = f;
      div_code = dv;
      step(2);
      write_byte(d);
      wait_start(ok);
      chk("R1 random frame started", ok, 1);
      sample_frame(d, f, dv, 0, fmt_tag(f));
      step(bit_cycles(dv));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule